// File: doc/BRIEF.md
# Set-Associative Write-Back Cache with Recency Replacement

This block is a write-allocate, write-back cache whose ways are a parameter (2 or 4). The low bits of a block address select a set. The remaining high bits form the tag, which is compared against every way of that set in the same cycle. A processor access that finds a valid way with a matching tag completes in the cycle it is presented. A read returns the stored block in that cycle, and a write replaces the stored block and marks it modified.

When no way matches, the block raises its stall output and picks one way of the set to replace. It picks an empty way if the set has one. Otherwise it picks the way that was touched longest ago. A modified victim is first sent to memory under its own tag and the current set. The requested block is then fetched and installed as valid and clean, and the original access is replayed against the filled entry. The processor must hold its request steady while stalled. The memory side moves whole blocks with a request/acknowledge pair.

Top module: `sa_cache`

## Requirements
- R1: After reset every way is empty: with no request the stall output and the memory request are low, and the first access to any address misses.
- R2: An access hits when a valid way of the indexed set (set = block address mod number of sets, tag = block address divided by number of sets) holds the requested tag. A hit completes with stall low in the cycle it is presented, and a read returns the stored block on the read data output in that cycle.
- R3: A write hit replaces the block in the matching way and causes no memory traffic. A later read of that address returns the new data.
- R4: A miss holds stall high. A clean victim causes exactly one memory read at the requested block address. After its acknowledge the replayed access hits, so a clean miss stalls for memory latency plus two cycles.
- R5: A modified victim is written to memory, with its data, at address tag × sets + set. This write-back (memory write enable high) is acknowledged before the fill read is issued.
- R6: An empty way in the indexed set is chosen as victim ahead of any valid way. As a result, as many distinct blocks as there are ways fit in one set without any eviction.
- R7: When the set is full, the victim is the way least recently touched. Both a hit and a refill count as a touch.
- R8: With 4 sets of 2 ways, alternating accesses to block addresses 0 and 8 (or 1 and 9) miss twice and then hit on every access.
- R9: Once the memory request is raised, it stays high with a stable address and direction until it is acknowledged.
- R10: A refill installs its block clean. A block that was only read is later evicted without a write-back. A block that was written after a write-allocate miss is written back when evicted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| proc_req | input | 1 | Processor access valid, held while stalled |
| proc_we | input | 1 | 1 = write, 0 = read |
| proc_addr | input | ADDR_W | Block address |
| proc_wdata | input | DATA_W | Block to write |
| proc_rdata | output | DATA_W | Block read on a hit |
| proc_stall | output | 1 | Access not complete this cycle |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write-back, 0 = fill read |
| mem_addr | output | ADDR_W | Memory block address |
| mem_wdata | output | DATA_W | Victim block being written back |
| mem_rdata | input | DATA_W | Fill data, valid with mem_ack |
| mem_ack | input | 1 | Transfer complete this cycle |

## Verification
The checker watches several properties on every cycle:
- the memory handshake holds steady until it is acknowledged;
- a memory transfer always keeps the processor stalled;
- a write-back is always followed by a fill, and an acknowledged fill leaves the replayed access unstalled;
- no more than one way ever matches;
- an empty way is always preferred as victim.

Which way is least recent, the contents of the blocks, the write-back address, and the dirty state surviving across hits and refills can only be seen over access sequences. The bench's recency-list model checks these on every access, together with the exact stall length.

// File: rtl/sa_cache_pkg.sv
package sa_cache_pkg;

    typedef enum logic [1:0] {
        ST_LOOKUP = 2'd0,
        ST_WRBACK = 2'd1,
        ST_FILL   = 2'd2
    } cache_state_e;

    function automatic int way_bits(input int ways);
        return (ways > 1) ? $clog2(ways) : 1;
    endfunction

endpackage

// File: rtl/sa_tag_match.sv
module sa_tag_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 4
) (
    input  logic [WAYS-1:0][TAG_W-1:0] way_tags,
    input  logic [WAYS-1:0]            way_valid,
    input  logic [TAG_W-1:0]           look_tag,
    output logic [WAYS-1:0]            hit_vec,
    output logic                       hit,
    output logic [sa_cache_pkg::way_bits(WAYS)-1:0] hit_way
);
    localparam int WAY_W = sa_cache_pkg::way_bits(WAYS);

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign hit_vec[g] = way_valid[g] && (way_tags[g] == look_tag);
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/sa_lru.sv
module sa_lru #(
    parameter int WAYS  = 2,
    parameter int SET_W = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   touch_en,
    input  logic [SET_W-1:0]       touch_set,
    input  logic [sa_cache_pkg::way_bits(WAYS)-1:0] touch_way,
    input  logic [SET_W-1:0]       look_set,
    input  logic [WAYS-1:0]        look_valid,
    output logic [sa_cache_pkg::way_bits(WAYS)-1:0] victim_way
);
    localparam int WAY_W = sa_cache_pkg::way_bits(WAYS);
    localparam int SETS  = 1 << SET_W;

    // age 0 = most recent, WAYS-1 = oldest; ages in a set form a permutation
    logic [WAY_W-1:0] age_q [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= WAY_W'(w);
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    age_q[touch_set][w] <= '0;
                else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
                    age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
            end
        end
    end

    always_comb begin
        logic found;
        found      = 1'b0;
        victim_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!look_valid[w] && !found) begin
                victim_way = WAY_W'(w);
                found      = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (age_q[look_set][w] == WAY_W'(WAYS - 1)) victim_way = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/sa_cache.sv
module sa_cache #(
    parameter int ADDR_W = 6,
    parameter int SET_W  = 2,
    parameter int WAYS   = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              proc_req,
    input  logic              proc_we,
    input  logic [ADDR_W-1:0] proc_addr,
    input  logic [DATA_W-1:0] proc_wdata,
    output logic [DATA_W-1:0] proc_rdata,
    output logic              proc_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    import sa_cache_pkg::*;

    localparam int SETS  = 1 << SET_W;
    localparam int TAG_W = ADDR_W - SET_W;
    localparam int WAY_W = way_bits(WAYS);

    cache_state_e state_q;

    logic [WAYS-1:0]   valid_q [SETS];
    logic [WAYS-1:0]   dirty_q [SETS];
    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic [DATA_W-1:0] data_q  [SETS][WAYS];
    logic [WAY_W-1:0]  victim_q;

    logic [SET_W-1:0]              set_idx;
    logic [TAG_W-1:0]              req_tag;
    logic [WAYS-1:0][TAG_W-1:0]    lk_tags;
    logic [WAYS-1:0]               lk_valid;
    logic [WAYS-1:0]               hit_vec;
    logic                          hit;
    logic [WAY_W-1:0]              hit_way;
    logic [WAY_W-1:0]              vic_way;
    logic                          in_lookup;
    logic                          hit_go;
    logic                          fill_done;

    assign set_idx   = proc_addr[SET_W-1:0];
    assign req_tag   = proc_addr[ADDR_W-1:SET_W];
    assign lk_valid  = valid_q[set_idx];
    assign in_lookup = (state_q == ST_LOOKUP);
    assign hit_go    = in_lookup && proc_req && hit;
    assign fill_done = (state_q == ST_FILL) && mem_ack;

    for (genvar g = 0; g < WAYS; g++) begin : g_rd
        assign lk_tags[g] = tag_q[set_idx][g];
    end

    sa_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .way_tags  (lk_tags),
        .way_valid (lk_valid),
        .look_tag  (req_tag),
        .hit_vec   (hit_vec),
        .hit       (hit),
        .hit_way   (hit_way)
    );

    sa_lru #(.WAYS(WAYS), .SET_W(SET_W)) u_lru (
        .clk        (clk),
        .rst        (rst),
        .touch_en   (hit_go || fill_done),
        .touch_set  (set_idx),
        .touch_way  (fill_done ? victim_q : hit_way),
        .look_set   (set_idx),
        .look_valid (lk_valid),
        .victim_way (vic_way)
    );

    // control and status bits
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_LOOKUP;
            victim_q <= '0;
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
            end
        end else begin
            case (state_q)
                ST_LOOKUP: begin
                    if (proc_req && !hit) begin
                        victim_q <= vic_way;
                        state_q  <= (lk_valid[vic_way] && dirty_q[set_idx][vic_way])
                                    ? ST_WRBACK : ST_FILL;
                    end else if (hit_go && proc_we) begin
                        dirty_q[set_idx][hit_way] <= 1'b1;
                    end
                end
                ST_WRBACK: if (mem_ack) state_q <= ST_FILL;
                ST_FILL: begin
                    if (mem_ack) begin
                        valid_q[set_idx][victim_q] <= 1'b1;
                        dirty_q[set_idx][victim_q] <= 1'b0;
                        state_q <= ST_LOOKUP;
                    end
                end
                default: state_q <= ST_LOOKUP;
            endcase
        end
    end

    // tag and data storage
    always_ff @(posedge clk) begin
        if (fill_done) begin
            tag_q[set_idx][victim_q]  <= req_tag;
            data_q[set_idx][victim_q] <= mem_rdata;
        end else if (hit_go && proc_we) begin
            data_q[set_idx][hit_way] <= proc_wdata;
        end
    end

    assign proc_rdata = data_q[set_idx][hit_way];
    assign proc_stall = !in_lookup || (proc_req && !hit);
    assign mem_req    = !in_lookup;
    assign mem_we     = (state_q == ST_WRBACK);
    assign mem_addr   = mem_we ? {tag_q[set_idx][victim_q], set_idx} : proc_addr;
    assign mem_wdata  = data_q[set_idx][victim_q];
endmodule

// File: rtl/sa_cache_chk.sv
module sa_cache_chk #(
    parameter int ADDR_W = 6,
    parameter int WAYS   = 2,
    parameter int WAY_W  = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              proc_req,
    input logic              proc_stall,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WAYS-1:0]   hit_vec,
    input logic [WAYS-1:0]   lk_valid,
    input logic [WAY_W-1:0]  vic_way,
    input logic              in_lookup
);
    a_r9_mem_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    a_r4_stall_during_mem: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> proc_stall);

    a_r5_wb_then_fill: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we && mem_ack |=> mem_req && !mem_we);

    a_r4_hit_after_fill: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_we && mem_ack |=> !proc_stall);

    a_r2_single_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    a_r6_empty_first: assert property (@(posedge clk) disable iff (rst)
        in_lookup && proc_req && !(|hit_vec) && !(&lk_valid) |-> !lk_valid[vic_way]);
endmodule

bind sa_cache sa_cache_chk #(
    .ADDR_W (ADDR_W),
    .WAYS   (WAYS),
    .WAY_W  (WAY_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .proc_req   (proc_req),
    .proc_stall (proc_stall),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .hit_vec    (hit_vec),
    .lk_valid   (lk_valid),
    .vic_way    (vic_way),
    .in_lookup  (in_lookup)
);

// File: tb/sa_cache_bench.sv
module sa_cache_bench;
    localparam int ADDR_W = 6;
    localparam int SET_W  = 2;
    localparam int WAYS   = 2;
    localparam int DATA_W = 32;
    localparam int SETS   = 1 << SET_W;
    localparam int LAT    = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              proc_req = 1'b0;
    logic              proc_we = 1'b0;
    logic [ADDR_W-1:0] proc_addr = '0;
    logic [DATA_W-1:0] proc_wdata = '0;
    logic [DATA_W-1:0] proc_rdata;
    logic              proc_stall;
    logic              mem_req;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;
    logic              mem_ack;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    sa_cache #(.ADDR_W(ADDR_W), .SET_W(SET_W), .WAYS(WAYS), .DATA_W(DATA_W)) u_sa_cache (
        .clk(clk), .rst(rst),
        .proc_req(proc_req), .proc_we(proc_we), .proc_addr(proc_addr),
        .proc_wdata(proc_wdata), .proc_rdata(proc_rdata), .proc_stall(proc_stall),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // ---------------- memory model ----------------
    logic [DATA_W-1:0] store [int];
    int lat_cnt = 0;

    function automatic logic [DATA_W-1:0] memval(input int a);
        if (store.exists(a)) return store[a];
        return 32'h1000_0000 + a * 32'h0001_0101;
    endfunction

    assign mem_ack   = mem_req && (lat_cnt == LAT);
    assign mem_rdata = memval(int'(mem_addr));

    always @(posedge clk) begin
        if (rst) lat_cnt <= 0;
        else if (mem_req && !mem_ack) lat_cnt <= lat_cnt + 1;
        else lat_cnt <= 0;
        if (!rst && mem_req && mem_ack && mem_we) store[int'(mem_addr)] = mem_wdata;
    end

    // ---------------- reference model ----------------
    bit                m_valid [SETS][WAYS];
    bit                m_dirty [SETS][WAYS];
    int                m_tag   [SETS][WAYS];
    logic [DATA_W-1:0] m_data  [SETS][WAYS];
    int                order   [SETS][$];   // front = most recent

    function automatic void touch(input int s, input int w);
        for (int i = 0; i < order[s].size(); i++)
            if (order[s][i] == w) begin order[s].delete(i); break; end
        order[s].push_front(w);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic access(input bit we, input int addr, input logic [DATA_W-1:0] wd,
                          input string req);
        int s, t, hw, vic, cyc, exp_cyc;
        bit wb;
        int ev_addr[$];
        bit ev_we[$];
        logic [DATA_W-1:0] ev_data[$];
        logic [DATA_W-1:0] got;
        int wb_addr;
        logic [DATA_W-1:0] wb_data;
        s = addr % SETS;
        t = addr / SETS;
        hw = -1;
        for (int w = 0; w < WAYS; w++)
            if (m_valid[s][w] && m_tag[s][w] == t) hw = w;
        vic = -1;
        wb = 0;
        if (hw < 0) begin
            for (int w = WAYS - 1; w >= 0; w--) if (!m_valid[s][w]) vic = w;
            if (vic < 0) vic = order[s][$];
            wb = m_valid[s][vic] && m_dirty[s][vic];
            wb_addr = m_tag[s][vic] * SETS + s;
            wb_data = m_data[s][vic];
        end
        exp_cyc = (hw >= 0) ? 1 : (LAT + 3 + (wb ? LAT + 1 : 0));

        proc_req = 1'b1; proc_we = we; proc_addr = ADDR_W'(addr); proc_wdata = wd;
        cyc = 0;
        got = '0;
        forever begin
            #1;
            cyc++;
            if (mem_req && mem_ack) begin
                ev_addr.push_back(int'(mem_addr));
                ev_we.push_back(mem_we);
                ev_data.push_back(mem_wdata);
            end
            if (!proc_stall) begin got = proc_rdata; break; end
            if (cyc > 100) break;
            @(negedge clk);
        end
        @(negedge clk);
        proc_req = 1'b0;

        // model update
        if (hw < 0) begin
            m_valid[s][vic] = 1; m_dirty[s][vic] = 0; m_tag[s][vic] = t;
            m_data[s][vic] = memval(addr);
            hw = vic;
        end
        touch(s, hw);
        if (we) begin m_data[s][hw] = wd; m_dirty[s][hw] = 1; end

        chk(cyc == exp_cyc, req, $sformatf("stall cycles addr %0d", addr), cyc, exp_cyc);
        if (!we) chk(got == m_data[s][hw], req, $sformatf("read data addr %0d", addr),
                     got, m_data[s][hw]);
        if (exp_cyc == 1) begin
            chk(ev_addr.size() == 0, req, "memory traffic on hit", ev_addr.size(), 0);
        end else begin
            chk(ev_addr.size() == (wb ? 2 : 1), req, "transfer count",
                ev_addr.size(), wb ? 2 : 1);
            if (ev_addr.size() == (wb ? 2 : 1)) begin
                if (wb) begin
                    chk(ev_we[0] == 1 && ev_addr[0] == wb_addr, "R5", "write-back address",
                        ev_addr[0], wb_addr);
                    chk(ev_data[0] == wb_data, "R5", "write-back data", ev_data[0], wb_data);
                end
                chk(ev_we[$] == 0 && ev_addr[$] == addr, req, "fill address",
                    ev_addr[$], addr);
            end
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #100000;
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) order[s].push_back(w);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R1: quiet after reset
        chk(proc_stall == 0, "R1", "stall idle", proc_stall, 0);
        chk(mem_req == 0, "R1", "mem_req idle", mem_req, 0);
        @(negedge clk);

        access(0, 0, '0, "R1");            // first access misses
        access(0, 0, '0, "R2");            // hit
        access(1, 0, 32'hCAFE_0001, "R3"); // write hit, no traffic
        access(0, 0, '0, "R3");            // read back
        access(0, 4, '0, "R6");            // fills the empty way
        access(0, 0, '0, "R6");
        access(0, 4, '0, "R6");            // both resident
        access(0, 8, '0, "R7");            // evicts dirty 0 (R5)
        access(0, 4, '0, "R7");            // 4 kept
        access(0, 0, '0, "R5");            // victim 8 clean (R10), data from write-back
        access(1, 12, 32'hBEEF_0012, "R10"); // write-allocate miss, victim 4
        access(0, 12, '0, "R10");
        access(0, 16, '0, "R7");           // victim 0 (clean)
        access(0, 20, '0, "R10");          // victim 12, dirty -> write-back
        // R8: alternating trace in set 1
        access(0, 1, '0, "R8");
        access(0, 9, '0, "R8");
        for (int i = 0; i < 3; i++) begin
            access(0, 1, '0, "R8");
            access(0, 9, '0, "R8");
        end
        // other sets stay independent
        access(1, 2, 32'h0000_2222, "R4");
        access(1, 10, 32'h0000_AAAA, "R4");
        access(0, 18, '0, "R7");           // evicts 2 (dirty)
        access(0, 10, '0, "R2");
        access(0, 2, '0, "R5");            // refetch written-back data

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule